// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns two quadrature phase signals and an index signal from a rotary or linear encoder into a 16-bit position count. It also produces a direction flag and a stream of velocity pulses that can be reduced by a prescaler. Each of the three inputs is synchronized by two flops. The decoder then looks at the phase relationship and classifies each single-phase transition as a forward or a reverse step. If both phases change in the same sample, the transition is illegal and is dropped.

A 3-bit mode field chooses one of three things: disabled, 2x resolution (edges of phase A only) or 4x resolution (edges of both phases). It also chooses how the count is brought back to zero: either by the index input or by a match against a maximum-count register. In index modes a wrap past either end of the 16-bit range sets an error flag that stays set until software clears it. The phase pins are shared with an input-capture function. The encoder owns them whenever its mode is active, and capture is granted only while the mode field is in an off code.

Software reaches the block through a small register port. A write strobe, a 2-bit address and 16-bit write data update the registers. The read data reflects the addressed register in the same cycle.

Top module: `qenc_pos_if`

## Requirements
- R1: After reset the control byte, the position register and the maximum-count register all read 0. Address 0 is the control byte, address 1 is the position, address 2 is the maximum count, and address 3 reads 0.
- R2: Mode codes 000, 011, 100 and 111 are off. Phase activity leaves the position unchanged in these codes.
- R3: In 4x modes (101, 110), every single-phase edge of A or B moves the position by one. It increments when A leads B (sequence {A,B} = 00,10,11,01) and decrements in the opposite order.
- R4: In 2x modes (001, 010), only edges of phase A move the position. Edges of B are ignored.
- R5: Control bit 5 reads 1 after a forward step and 0 after a reverse step. Writes to bit 5 do not change it.
- R6: In index modes (001, 101), a high index input forces the position to 0. In period modes (010, 110), the index input has no effect.
- R7: In period modes, a forward step from a position equal to the maximum count gives 0. A reverse step from 0 gives the maximum count. The error bit is not set.
- R8: In index modes, a forward step from 0xFFFF gives 0 and a reverse step from 0 gives 0xFFFF. Either one sets control bit 6. That bit stays set through control writes with bit 6 = 1 and clears only on a control write with bit 6 = 0.
- R9: A sample in which both phases change together is ignored and does not move the position.
- R10: With control bit 7 = 0 and an active mode, the velocity output pulses high for one cycle once per N counted edges. N is 1, 4, 16 or 64 for control bits [1:0] = 00, 01, 10, 11. The step tally restarts on every control write. With bit 7 = 1, no pulses are produced.
- R11: The capture grant output equals the capture request while the mode is an off code. It is 0 in all active modes.
- R12: Writes to addresses 1 and 2 load the position and the maximum count. Control bits [7], [4:2] and [1:0] are loaded from a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a_i | input | 1 | Phase A, asynchronous |
| enc_b_i | input | 1 | Phase B, asynchronous |
| enc_idx_i | input | 1 | Index input, asynchronous |
| cap_req_i | input | 1 | Input-capture function requests the shared pins |
| cap_grant_o | output | 1 | Shared pins granted to input capture |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the addressed register |
| vel_pulse_o | output | 1 | Prescaled velocity pulse, one cycle wide |

## Verification
A fault in the edge decoder or the direction logic shows up three clocks after the input edge. At that point the position register or control bit 5 reads one count off, or has moved the wrong way. A fault in the wrap or match logic shows up only at the range ends. The bench therefore preloads the position next to 0xFFFF, 0 and the maximum count, and it checks the error bit in the same read. A fault in the prescaler only becomes visible after N counted edges, as a missing or extra pulse. So the pulse total is compared once every ratio has run a full period.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_POS  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MAX  = 2'd2;

    // decoded view of the 3-bit mode field
    typedef struct packed {
        logic active;
        logic four_x;
        logic idx_reset;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(input logic [2:0] code);
        mode_dec_t m;
        m = '0;
        unique case (code)
            3'b001: m = '{active: 1'b1, four_x: 1'b0, idx_reset: 1'b1};
            3'b010: m = '{active: 1'b1, four_x: 1'b0, idx_reset: 1'b0};
            3'b101: m = '{active: 1'b1, four_x: 1'b1, idx_reset: 1'b1};
            3'b110: m = '{active: 1'b1, four_x: 1'b1, idx_reset: 1'b0};
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/qenc_edge.sv
module qenc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    input  logic en_i,
    input  logic four_x_i,
    output logic step_up_o,
    output logic step_dn_o
);

    typedef struct packed {
        logic a;
        logic b;
    } prev_t;

    prev_t s_d, s_q;
    logic  da, db, up, dn;

    always_comb begin
        s_d.a = a_i;
        s_d.b = b_i;
        da    = a_i ^ s_q.a;
        db    = b_i ^ s_q.b;
        up    = 1'b0;
        dn    = 1'b0;
        // both phases moving in one sample is illegal: drop it
        if (en_i && !(da && db)) begin
            if (da) begin
                up = a_i ^ b_i;
                dn = ~(a_i ^ b_i);
            end else if (db && four_x_i) begin
                up = ~(a_i ^ b_i);
                dn = a_i ^ b_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign step_up_o = up;
    assign step_dn_o = dn;

    assert_one_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up_o && step_dn_o));

    assert_b_ignored_2x_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!four_x_i && (a_i == s_q.a)) |-> !(step_up_o || step_dn_o));

endmodule

// File: rtl/qenc_velpre.sv
module qenc_velpre #(
    parameter int unsigned DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       restart_i,
    input  logic       step_i,
    input  logic [1:0] ratio_i,
    output logic       pulse_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             pulse;
    } vp_t;

    vp_t              v_d, v_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = DIV_W'((32'd1 << {ratio_i, 1'b0}) - 32'd1);
        v_d   = v_q;
        v_d.pulse = 1'b0;
        if (restart_i || !en_i) begin
            v_d.cnt = '0;
        end else if (step_i) begin
            if (v_q.cnt >= lim) begin
                v_d.cnt   = '0;
                v_d.pulse = 1'b1;
            end else begin
                v_d.cnt = v_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign pulse_o = v_q.pulse;

    assert_pulse_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(en_i));

endmodule

// File: rtl/qenc_pos_if.sv
module qenc_pos_if
    import qenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a_i,
    input  logic              enc_b_i,
    input  logic              enc_idx_i,
    input  logic              cap_req_i,
    output logic              cap_grant_o,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [CNT_W-1:0]  reg_wdata_i,
    output logic [CNT_W-1:0]  reg_rdata_o,
    output logic              vel_pulse_o
);

    localparam logic [CNT_W-1:0] TOP_VAL = '1;

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] maxc;
        logic             velm;
        logic             err;
        logic             dir;
        logic [2:0]       mode;
        logic [1:0]       pdec;
    } st_t;

    st_t       q, d;
    mode_dec_t md;
    logic [2:0] syn;
    logic      up, dn, err_set, ctrl_wr;

    qenc_sync #(.W(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({enc_idx_i, enc_b_i, enc_a_i}),
        .sync_o  (syn)
    );

    assign md = decode_mode(q.mode);

    qenc_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_i       (syn[0]),
        .b_i       (syn[1]),
        .en_i      (md.active),
        .four_x_i  (md.four_x),
        .step_up_o (up),
        .step_dn_o (dn)
    );

    assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);

    qenc_velpre #(.DIV_W(6)) u_vel (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (md.active && !q.velm),
        .restart_i (ctrl_wr),
        .step_i    (up || dn),
        .ratio_i   (q.pdec),
        .pulse_o   (vel_pulse_o)
    );

    always_comb begin
        d       = q;
        err_set = 1'b0;
        if (md.active) begin
            if (up || dn) d.dir = up;
            if (md.idx_reset && syn[2]) begin
                d.pos = '0;
            end else if (up) begin
                if (md.idx_reset) begin
                    if (q.pos == TOP_VAL) err_set = 1'b1;
                    d.pos = q.pos + 1'b1;
                end else begin
                    d.pos = (q.pos == q.maxc) ? '0 : q.pos + 1'b1;
                end
            end else if (dn) begin
                if (md.idx_reset) begin
                    if (q.pos == '0) err_set = 1'b1;
                    d.pos = q.pos - 1'b1;
                end else begin
                    d.pos = (q.pos == '0) ? q.maxc : q.pos - 1'b1;
                end
            end
        end
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                ADDR_POS: d.pos  = reg_wdata_i;
                ADDR_MAX: d.maxc = reg_wdata_i;
                ADDR_CTRL: begin
                    d.velm = reg_wdata_i[7];
                    d.mode = reg_wdata_i[4:2];
                    d.pdec = reg_wdata_i[1:0];
                end
                default: ;
            endcase
        end
        d.err = (q.err && !(ctrl_wr && !reg_wdata_i[6])) || err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr_i)
            ADDR_CTRL: reg_rdata_o = {8'h00, q.velm, q.err, q.dir, q.mode, q.pdec};
            ADDR_POS:  reg_rdata_o = q.pos;
            ADDR_MAX:  reg_rdata_o = q.maxc;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign cap_grant_o = cap_req_i && !md.active;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.err) && !($past(ctrl_wr) && !$past(reg_wdata_i[6]))) |-> q.err);

    assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!md.active && !reg_wr_i) |=> $stable(q.pos));

    assert_unit_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (md.active && !reg_wr_i) |=>
            (q.pos == $past(q.pos)) || (q.pos == $past(q.pos) + 16'd1) ||
            (q.pos == $past(q.pos) - 16'd1) || (q.pos == '0) || (q.pos == $past(q.maxc)));

    assert_period_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (md.active && !md.idx_reset && !q.err) |=> !q.err);

endmodule

// File: tb/qenc_pos_if_test.sv
module qenc_pos_if_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a = 1'b0, b = 1'b0, idx = 1'b0, cap_req = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        grant, vpulse;

    int n_chk = 0, n_bad = 0, vel_cnt = 0, ph = 0;
    bit done = 0;

    always #10 clk = ~clk;

    qenc_pos_if uut (
        .clk(clk), .rst_n(rst_n), .enc_a_i(a), .enc_b_i(b), .enc_idx_i(idx),
        .cap_req_i(cap_req), .cap_grant_o(grant), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .vel_pulse_o(vpulse)
    );

    always @(negedge clk) if (rst_n && vpulse) vel_cnt++;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] ad, input logic [15:0] v);
        @(negedge clk); wr = 1'b1; addr = ad; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] ad, output logic [15:0] v);
        @(negedge clk); addr = ad; #1 v = rdata;
    endtask

    function automatic logic [1:0] gray(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    // dir = +1 forward, -1 reverse, +2 illegal double change
    task automatic mv(input int dir, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ph = (ph + dir + 4) & 3;
            {a, b} = gray(ph);
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        cap_req = 1'b1;
        rreg(2'd0, v); check("R1 ctrl", v, 16'h0000);
        rreg(2'd1, v); check("R1 pos", v, 16'h0000);
        rreg(2'd2, v); check("R1 max", v, 16'h0000);
        rreg(2'd3, v); check("R1 addr3", v, 16'h0000);
        check("R11 grant at reset", {15'd0, grant}, 16'd1);
    endtask

    task automatic t_off;
        logic [15:0] v;
        int codes[4] = '{0, 3, 4, 7};
        foreach (codes[k]) begin
            wreg(2'd1, 16'h0100);
            wreg(2'd0, 16'((codes[k] << 2) | 8'h80));
            mv(1, 2);
            rreg(2'd1, v); check("R2 off holds", v, 16'h0100);
            check("R11 grant off", {15'd0, grant}, 16'd1);
        end
        wreg(2'd0, 16'h0084);
        #1 check("R11 grant active", {15'd0, grant}, 16'd0);
    endtask

    task automatic t_4x;
        logic [15:0] v;
        wreg(2'd0, 16'h0094);              // 101, velocity off
        wreg(2'd1, 16'h0010);
        mv(1, 5);
        rreg(2'd1, v); check("R3 4x fwd", v, 16'h0015);
        rreg(2'd0, v); check("R5 dir fwd", {15'd0, v[5]}, 16'd1);
        mv(-1, 3);
        rreg(2'd1, v); check("R3 4x rev", v, 16'h0012);
        rreg(2'd0, v); check("R5 dir rev", {15'd0, v[5]}, 16'd0);
        wreg(2'd0, 16'h00B4);              // try to set dir bit
        rreg(2'd0, v); check("R5 dir read-only", {15'd0, v[5]}, 16'd0);
        check("R12 ctrl fields", v & 16'h009F, 16'h0094);
    endtask

    task automatic t_2x;
        logic [15:0] v;
        wreg(2'd0, 16'h0084);              // 001
        wreg(2'd1, 16'h0020);
        mv(1, 8);
        rreg(2'd1, v); check("R4 2x fwd", v, 16'h0024);
        mv(-1, 4);
        rreg(2'd1, v); check("R4 2x rev", v, 16'h0022);
    endtask

    task automatic t_illegal;
        logic [15:0] v;
        wreg(2'd0, 16'h0094);
        wreg(2'd1, 16'h0040);
        mv(2, 1);
        rreg(2'd1, v); check("R9 double change", v, 16'h0040);
        mv(1, 1);
        rreg(2'd1, v); check("R9 resume", v, 16'h0041);
    endtask

    task automatic t_index;
        logic [15:0] v;
        wreg(2'd0, 16'h0094);
        wreg(2'd1, 16'h0033);
        @(negedge clk); idx = 1'b1; repeat (2) @(negedge clk); idx = 1'b0;
        repeat (4) @(negedge clk);
        rreg(2'd1, v); check("R6 index reset", v, 16'h0000);
        wreg(2'd0, 16'h0098);              // 110 period
        wreg(2'd2, 16'h0100);
        wreg(2'd1, 16'h0033);
        @(negedge clk); idx = 1'b1; repeat (2) @(negedge clk); idx = 1'b0;
        repeat (4) @(negedge clk);
        rreg(2'd1, v); check("R6 index ignored", v, 16'h0033);
    endtask

    task automatic t_period;
        logic [15:0] v;
        wreg(2'd0, 16'h0098);
        wreg(2'd2, 16'h0005);
        wreg(2'd1, 16'h0004);
        mv(1, 1);
        rreg(2'd1, v); check("R7 reach max", v, 16'h0005);
        mv(1, 1);
        rreg(2'd1, v); check("R7 match to 0", v, 16'h0000);
        mv(-1, 1);
        rreg(2'd1, v); check("R7 under to max", v, 16'h0005);
        rreg(2'd0, v); check("R7 no err", {15'd0, v[6]}, 16'd0);
        rreg(2'd2, v); check("R12 max reg", v, 16'h0005);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wreg(2'd0, 16'h0094);
        wreg(2'd1, 16'hFFFF);
        mv(1, 1);
        rreg(2'd1, v); check("R8 over wrap", v, 16'h0000);
        rreg(2'd0, v); check("R8 err set", {15'd0, v[6]}, 16'd1);
        wreg(2'd0, 16'h00D4);
        rreg(2'd0, v); check("R8 err kept", {15'd0, v[6]}, 16'd1);
        wreg(2'd0, 16'h0094);
        rreg(2'd0, v); check("R8 err cleared", {15'd0, v[6]}, 16'd0);
        mv(-1, 1);
        rreg(2'd1, v); check("R8 under wrap", v, 16'hFFFF);
        rreg(2'd0, v); check("R8 err underflow", {15'd0, v[6]}, 16'd1);
        wreg(2'd0, 16'h0094);
    endtask

    task automatic t_vel;
        int ratios[4] = '{1, 4, 16, 64};
        int steps[4]  = '{5, 8, 32, 64};
        foreach (ratios[k]) begin
            wreg(2'd0, 16'(16'h0014 | k));  // 101, velocity on
            vel_cnt = 0;
            mv(1, steps[k]);
            check("R10 vel pulses", 16'(vel_cnt), 16'(steps[k] / ratios[k]));
        end
        wreg(2'd0, 16'h0094);
        vel_cnt = 0;
        mv(1, 8);
        check("R10 vel disabled", 16'(vel_cnt), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_off;
        t_4x;
        t_2x;
        t_illegal;
        t_index;
        t_period;
        t_wrap;
        t_vel;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule